// File: doc/BRIEF.md
# Linked Descriptor Walker

This block drives a serial flash engine from a chain of transfer descriptors held in memory. Software writes the address of the first descriptor, then sets the enable and go bits of a small control word. The walker reads each descriptor through a single-word read port and checks that the hardware owns it. It then hands one transfer command to the serial engine and waits for that engine to report completion. After that it either follows the descriptor's link to the next one or stops.

A descriptor occupies four consecutive 32-bit words. Word 0 holds the control bits, word 1 is a status word the walker never reads, word 2 holds the data buffer address, and word 3 holds the link to the next descriptor. The control word sets the byte count, the direction, the lane width, double data rate, bit order, the target device and whether chip select is released after the transfer. It also holds the end-of-chain flag and two notification enables. The walker pulses one event per finished descriptor that asks for it, one event when a packet finishes, and one error event when a chain breaks. The address of the descriptor in progress is always visible.

Top module: `desc_walker`

## Requirements
- R1: After reset, `mem_rd_req`, `cmd_valid` and all three event outputs are low, and `cur_desc_addr` is zero.
- R2: In idle, with `ctl_bits[0]` (enable) and `ctl_bits[2]` (go) both high, the walker loads `base_addr` into `cur_desc_addr`. It then reads the words at offsets +0, +8 and +12, in that order, and never reads +4. A read request holds its address until `mem_rd_valid`, and data is taken on the edge where both are high. Go has no effect while enable is low.
- R3: For a descriptor whose control bit 31 (owned) is set, `cmd_valid` rises with the following fields. Length is bits 8:0 and receive is bit 20. DDR is bit 21, dual is bit 22 and quad is bit 23. LSB-first is bit 25, device select is bits 29:28, chip-select release is bit 30 and last-of-packet is bit 18. The buffer address comes from word 2. All other control bits are ignored. The fields stay stable until `cmd_done`, and `cmd_valid` is low in the cycle after the edge that samples `cmd_done`.
- R4: When a finished descriptor has bit 19 (end of chain) clear and a nonzero link, the next control read goes to the link address.
- R5: `evt_desc_done` pulses for exactly the cycle after the `cmd_done` edge when the finished descriptor has bit 16 set.
- R6: `evt_pkt_done` pulses in that same cycle when the finished descriptor has both bit 19 and bit 17 set. With bit 17 clear, no packet event occurs. Either way the walker then idles.
- R7: With `ctl_bits[1]` (poll) high, a control word with bit 31 clear is read again from the same address until bit 31 is found set. The walker then continues normally.
- R8: With poll low, a control word with bit 31 clear ends the walk: no further reads, no command and no events.
- R9: A finished descriptor with bit 19 clear and a link of zero pulses `evt_dma_err` in the cycle after the `cmd_done` edge, and the walker idles.
- R10: When enable goes low, `cmd_valid` and `mem_rd_req` are low from the next cycle on, whatever the state.
- R11: `cur_desc_addr` shows the address of the descriptor whose command is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_bits | input | 3 | Bit 0 enable, bit 1 poll, bit 2 go |
| base_addr | input | ADDR_W | Address of the first descriptor |
| mem_rd_req | output | 1 | Read request, held until valid |
| mem_rd_addr | output | ADDR_W | Byte address of the word being read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command presented |
| cmd_len | output | 9 | Byte count |
| cmd_rx | output | 1 | Receive direction (0 transmit) |
| cmd_ddr | output | 1 | Double data rate |
| cmd_dual | output | 1 | Two data lanes |
| cmd_quad | output | 1 | Four data lanes |
| cmd_lsb_first | output | 1 | Least significant bit first |
| cmd_dev_sel | output | 2 | Target device |
| cmd_cs_release | output | 1 | Release chip select after transfer |
| cmd_pkt_last | output | 1 | Last data of packet |
| cmd_buf_addr | output | ADDR_W | Data buffer address |
| cmd_done | input | 1 | Engine finished the command |
| evt_desc_done | output | 1 | Descriptor finished (enabled by bit 16) |
| evt_pkt_done | output | 1 | Packet finished |
| evt_dma_err | output | 1 | Broken chain |
| cur_desc_addr | output | ADDR_W | Descriptor in progress |

## Verification
Each read request is answered only after the bench sees it on a falling edge, and the expected address is compared at that moment. The expected address comes from a walk of the bench's own memory image. The events and the fall of `cmd_valid` are due one cycle after the rising edge that samples `cmd_done`, so the bench checks them at the very next falling edge: every event must appear while the bench still drives `cmd_done`. The enable drop is checked at the first falling edge after the edge that samples it. New commands are compared field by field, together with `cur_desc_addr`, in the cycle `cmd_valid` rises.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 9;
    // byte offsets of descriptor words
    localparam int OFS_BUF  = 8;
    localparam int OFS_LINK = 12;
    // control-word bit positions
    localparam int B_DESC_IE = 16;
    localparam int B_PKT_IE  = 17;
    localparam int B_PKTLAST = 18;
    localparam int B_EOC     = 19;
    localparam int B_RX      = 20;
    localparam int B_DDR     = 21;
    localparam int B_DUAL    = 22;
    localparam int B_QUAD    = 23;
    localparam int B_LSBF    = 25;
    localparam int B_SEL     = 28;
    localparam int B_REL     = 30;
    localparam int B_OWN     = 31;
    // control-input bit positions
    localparam int CB_EN   = 0;
    localparam int CB_POLL = 1;
    localparam int CB_GO   = 2;

    typedef enum logic [2:0] {
        WS_IDLE, WS_RD_CTRL, WS_RD_BUF, WS_RD_LINK, WS_EXEC
    } walk_st_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             rx;
        logic             ddr;
        logic             dual;
        logic             quad;
        logic             lsb_first;
        logic [1:0]       dev_sel;
        logic             cs_release;
        logic             pkt_last;
    } xfer_attr_t;

    typedef struct packed {
        logic eoc;
        logic desc_ie;
        logic pkt_ie;
    } fin_flags_t;

    function automatic xfer_attr_t attr_of(input logic [WORD_W-1:0] w);
        xfer_attr_t a;
        a.len        = w[LEN_W-1:0];
        a.rx         = w[B_RX];
        a.ddr        = w[B_DDR];
        a.dual       = w[B_DUAL];
        a.quad       = w[B_QUAD];
        a.lsb_first  = w[B_LSBF];
        a.dev_sel    = w[B_SEL+1:B_SEL];
        a.cs_release = w[B_REL];
        a.pkt_last   = w[B_PKTLAST];
        return a;
    endfunction

    function automatic fin_flags_t flags_of(input logic [WORD_W-1:0] w);
        fin_flags_t f;
        f.eoc     = w[B_EOC];
        f.desc_ie = w[B_DESC_IE];
        f.pkt_ie  = w[B_PKT_IE];
        return f;
    endfunction
endpackage

// File: rtl/bdp_decode.sv
module bdp_decode
    import bdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output xfer_attr_t        attr,
    output fin_flags_t        flags,
    output logic              owned
);
    always_comb begin
        attr  = attr_of(word);
        flags = flags_of(word);
        owned = word[B_OWN];
    end

    // bits of the control word with no function here (R3: ignored)
    logic rsvd_unused;
    assign rsvd_unused = ^{word[15:LEN_W], word[24], word[27:26]};
endmodule

// File: rtl/bdp_seq.sv
module bdp_seq
    import bdp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              poll,
    input  logic              go,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    input  xfer_attr_t        dec_attr,
    input  fin_flags_t        dec_flags,
    input  logic              dec_owned,
    output logic              cmd_valid,
    output xfer_attr_t        cmd_attr,
    output logic [ADDR_W-1:0] cmd_buf_addr,
    input  logic              cmd_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              fin,
    output fin_flags_t        fin_flags,
    output logic              chain_err
);
    walk_st_e          st;
    xfer_attr_t        attr_q;
    fin_flags_t        flags_q;
    logic [ADDR_W-1:0] buf_q;
    logic [ADDR_W-1:0] link_q;
    logic              take;

    assign take = mem_rd_req && mem_rd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WS_IDLE;
            cur_addr <= '0;
            attr_q  <= '0;
            flags_q <= '0;
            buf_q   <= '0;
            link_q  <= '0;
        end else if (!en) begin
            st <= WS_IDLE;
        end else begin
            unique case (st)
                WS_IDLE: if (go) begin
                    cur_addr <= base_addr;
                    st       <= WS_RD_CTRL;
                end
                WS_RD_CTRL: if (take) begin
                    attr_q  <= dec_attr;
                    flags_q <= dec_flags;
                    if (dec_owned)  st <= WS_RD_BUF;
                    else if (!poll) st <= WS_IDLE;
                end
                WS_RD_BUF: if (take) begin
                    buf_q <= mem_rd_data[ADDR_W-1:0];
                    st    <= WS_RD_LINK;
                end
                WS_RD_LINK: if (take) begin
                    link_q <= mem_rd_data[ADDR_W-1:0];
                    st     <= WS_EXEC;
                end
                WS_EXEC: if (cmd_done) begin
                    if (flags_q.eoc || link_q == '0) begin
                        st <= WS_IDLE;
                    end else begin
                        cur_addr <= link_q;
                        st       <= WS_RD_CTRL;
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            WS_RD_BUF:  mem_rd_addr = cur_addr + ADDR_W'(OFS_BUF);
            WS_RD_LINK: mem_rd_addr = cur_addr + ADDR_W'(OFS_LINK);
            default:    mem_rd_addr = cur_addr;
        endcase
    end

    assign mem_rd_req   = (st == WS_RD_CTRL) || (st == WS_RD_BUF) || (st == WS_RD_LINK);
    assign cmd_valid    = (st == WS_EXEC);
    assign cmd_attr     = attr_q;
    assign cmd_buf_addr = buf_q;
    assign fin          = en && cmd_valid && cmd_done;
    assign fin_flags    = flags_q;
    assign chain_err    = fin && !flags_q.eoc && (link_q == '0);

    // R2: an outstanding read keeps its address until answered
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_valid && en |=> mem_rd_req && $stable(mem_rd_addr));
    // R3: presented command is frozen until the engine finishes it
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_done && en |=> cmd_valid && $stable(cmd_attr) && $stable(cmd_buf_addr));
    // R3: command withdrawn right after completion
    p_cmd_drop_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_done |=> !cmd_valid);
    // R10: disabling stops all activity on the next cycle
    p_disable_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> !cmd_valid && !mem_rd_req);
endmodule

// File: rtl/bdp_events.sv
module bdp_events
    import bdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fin,
    input  fin_flags_t fin_flags,
    input  logic       chain_err,
    output logic       evt_desc_done,
    output logic       evt_pkt_done,
    output logic       evt_dma_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_desc_done <= 1'b0;
            evt_pkt_done  <= 1'b0;
            evt_dma_err   <= 1'b0;
        end else begin
            evt_desc_done <= fin && fin_flags.desc_ie;
            evt_pkt_done  <= fin && fin_flags.eoc && fin_flags.pkt_ie;
            evt_dma_err   <= chain_err;
        end
    end

    // R5: descriptor event only after a finish
    p_desc_cause_r5: assert property (@(posedge clk) disable iff (rst)
        evt_desc_done |-> $past(fin));
    // R6: packet event only after a finish
    p_pkt_cause_r6: assert property (@(posedge clk) disable iff (rst)
        evt_pkt_done |-> $past(fin));
    // R9: a broken chain never also completes a packet
    p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_pkt_done, evt_dma_err}));
endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import bdp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ctl_bits,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              cmd_valid,
    output logic [8:0]        cmd_len,
    output logic              cmd_rx,
    output logic              cmd_ddr,
    output logic              cmd_dual,
    output logic              cmd_quad,
    output logic              cmd_lsb_first,
    output logic [1:0]        cmd_dev_sel,
    output logic              cmd_cs_release,
    output logic              cmd_pkt_last,
    output logic [ADDR_W-1:0] cmd_buf_addr,
    input  logic              cmd_done,
    output logic              evt_desc_done,
    output logic              evt_pkt_done,
    output logic              evt_dma_err,
    output logic [ADDR_W-1:0] cur_desc_addr
);
    xfer_attr_t dec_attr;
    fin_flags_t dec_flags;
    logic       dec_owned;
    xfer_attr_t attr;
    fin_flags_t fin_flags;
    logic       fin;
    logic       chain_err;

    bdp_decode u_dec (
        .word  (mem_rd_data),
        .attr  (dec_attr),
        .flags (dec_flags),
        .owned (dec_owned)
    );

    bdp_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .en           (ctl_bits[CB_EN]),
        .poll         (ctl_bits[CB_POLL]),
        .go           (ctl_bits[CB_GO]),
        .base_addr    (base_addr),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .dec_attr     (dec_attr),
        .dec_flags    (dec_flags),
        .dec_owned    (dec_owned),
        .cmd_valid    (cmd_valid),
        .cmd_attr     (attr),
        .cmd_buf_addr (cmd_buf_addr),
        .cmd_done     (cmd_done),
        .cur_addr     (cur_desc_addr),
        .fin          (fin),
        .fin_flags    (fin_flags),
        .chain_err    (chain_err)
    );

    bdp_events u_evt (
        .clk           (clk),
        .rst           (rst),
        .fin           (fin),
        .fin_flags     (fin_flags),
        .chain_err     (chain_err),
        .evt_desc_done (evt_desc_done),
        .evt_pkt_done  (evt_pkt_done),
        .evt_dma_err   (evt_dma_err)
    );

    assign cmd_len        = attr.len;
    assign cmd_rx         = attr.rx;
    assign cmd_ddr        = attr.ddr;
    assign cmd_dual       = attr.dual;
    assign cmd_quad       = attr.quad;
    assign cmd_lsb_first  = attr.lsb_first;
    assign cmd_dev_sel    = attr.dev_sel;
    assign cmd_cs_release = attr.cs_release;
    assign cmd_pkt_last   = attr.pkt_last;
endmodule

// File: tb/tb_desc_walker.sv
`timescale 1ns/1ps
module tb_desc_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ctl_bits = 3'b000;
    logic [31:0] base_addr = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        cmd_valid;
    logic [8:0]  cmd_len;
    logic        cmd_rx, cmd_ddr, cmd_dual, cmd_quad, cmd_lsb_first;
    logic [1:0]  cmd_dev_sel;
    logic        cmd_cs_release, cmd_pkt_last;
    logic [31:0] cmd_buf_addr;
    logic        cmd_done = 1'b0;
    logic        evt_desc_done, evt_pkt_done, evt_dma_err;
    logic [31:0] cur_desc_addr;

    always #2.5 clk = ~clk;

    desc_walker dut (.*);

    int n_cmp = 0;
    int n_fail = 0;
    logic [31:0] mem [256];
    logic [31:0] rd_q[$];
    logic [95:0] cmd_q[$];
    int          ev_q[$];
    bit          eng_hold = 1'b0;
    logic [31:0] flip_addr = 32'hFFFF_FFFF;
    int          flip_after = 0;

    task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] pack_exp(input logic [31:0] a, input logic [31:0] c, input logic [31:0] b);
        return {14'd0, a, b, c[30], c[29:28], c[25], c[23], c[22], c[21], c[20], c[18], c[8:0]};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] b, input logic [31:0] nx);
        mem[a[9:2]]      = c;
        mem[a[9:2] + 1]  = 32'h5A5A_0000 | a;
        mem[a[9:2] + 2]  = b;
        mem[a[9:2] + 3]  = nx;
    endtask

    // reference walk of the bench memory image
    task automatic build_expect(input logic [31:0] base);
        logic [31:0] a, c, b, nx;
        int ev;
        a = base;
        for (int k = 0; k < 32; k++) begin
            c  = mem[a[9:2]];
            b  = mem[a[9:2] + 2];
            nx = mem[a[9:2] + 3];
            rd_q.push_back(a);
            if (!c[31]) break;
            rd_q.push_back(a + 8);
            rd_q.push_back(a + 12);
            cmd_q.push_back(pack_exp(a, c, b));
            ev = (c[16] ? 1 : 0) | ((c[19] && c[17]) ? 2 : 0) | ((!c[19] && nx == 0) ? 4 : 0);
            if (ev != 0) ev_q.push_back(ev);
            if (c[19] || nx == 0) break;
            a = nx;
        end
    endtask

    // memory responder, serial engine and monitors, all on falling edges
    initial begin
        int  wait_n = 0;
        int  lat = 0;
        int  eng_n = 0;
        int  flip_cnt = 0;
        bit  prev_cv = 1'b0;
        logic [95:0] act, exp;
        int  evm, eexp;
        forever begin
            @(negedge clk);
            if (!rst) begin
                // new command: fields and current descriptor (R3, R11)
                if (cmd_valid && !prev_cv) begin
                    act = {14'd0, cur_desc_addr, cmd_buf_addr, cmd_cs_release, cmd_dev_sel, cmd_lsb_first,
                           cmd_quad, cmd_dual, cmd_ddr, cmd_rx, cmd_pkt_last, cmd_len};
                    exp = (cmd_q.size() != 0) ? cmd_q.pop_front() : '1;
                    check(act == exp, "R3/R11 command fields and descriptor address", act, exp);
                end
                prev_cv = cmd_valid;
                // events: due while done is still driven (R5, R6, R9)
                evm = {29'd0, evt_dma_err, evt_pkt_done, evt_desc_done};
                if (evm != 0) begin
                    eexp = (ev_q.size() != 0) ? ev_q.pop_front() : 0;
                    check(evm == eexp, "R5/R6/R9 event set", 96'(evm), 96'(eexp));
                    check(cmd_done, "R5 event timing one cycle after done", 96'(cmd_done), 96'd1);
                end
                // serial engine
                if (cmd_done) begin
                    cmd_done = 1'b0;
                    eng_n = 0;
                    check(!cmd_valid, "R3 command dropped after done", 96'(cmd_valid), 96'd0);
                end else if (cmd_valid && !eng_hold) begin
                    eng_n++;
                    if (eng_n == 3) cmd_done = 1'b1;
                end else begin
                    eng_n = 0;
                end
                // memory
                if (mem_rd_valid) begin
                    mem_rd_valid = 1'b0;
                    wait_n = 0;
                end else if (mem_rd_req) begin
                    if (wait_n >= lat) begin
                        exp = (rd_q.size() != 0) ? 96'(rd_q.pop_front()) : '1;
                        check(96'(mem_rd_addr) == exp, "R2/R4/R7 read address", 96'(mem_rd_addr), exp);
                        mem_rd_data  = mem[mem_rd_addr[9:2]];
                        mem_rd_valid = 1'b1;
                        lat = 1 - lat;
                        if (mem_rd_addr == flip_addr) begin
                            flip_cnt++;
                            if (flip_cnt == flip_after) mem[flip_addr[9:2]][31] = 1'b1;
                        end
                    end else begin
                        wait_n++;
                    end
                end else begin
                    wait_n = 0;
                end
            end
        end
    end

    task automatic launch(input logic [31:0] base, input bit poll);
        base_addr = base;
        ctl_bits  = {1'b1, poll, 1'b1};
        @(negedge clk);
        ctl_bits  = {1'b0, poll, 1'b1};
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (n < 3000 && !(rd_q.size() == 0 && cmd_q.size() == 0 && ev_q.size() == 0
                             && !mem_rd_req && !cmd_valid)) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
        check(rd_q.size() == 0 && cmd_q.size() == 0 && ev_q.size() == 0 && !mem_rd_req && !cmd_valid,
              tag, 96'(rd_q.size() + cmd_q.size() + ev_q.size()), 96'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!mem_rd_req && !cmd_valid, "R1 no request or command after reset", 96'({mem_rd_req, cmd_valid}), 96'd0);
        check({evt_desc_done, evt_pkt_done, evt_dma_err} == 3'b000, "R1 events low after reset",
              96'({evt_desc_done, evt_pkt_done, evt_dma_err}), 96'd0);
        check(cur_desc_addr == 0, "R1 descriptor address zero", 96'(cur_desc_addr), 96'd0);

        // R2 go without enable is ignored
        base_addr = 32'h40;
        ctl_bits  = 3'b100;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!mem_rd_req && cur_desc_addr == 0, "R2 go ignored while disabled", 96'(mem_rd_req), 96'd0);
        end
        ctl_bits = 3'b000;

        // R2 R3 R4 R5 R6 R11: three-descriptor chain
        put_desc(32'h040, 32'h9041_0010, 32'h2000, 32'h100);
        put_desc(32'h100, 32'hA2B0_1100, 32'h3000, 32'h080);
        put_desc(32'h080, 32'hC00F_0001, 32'h4004, 32'h3C0);
        build_expect(32'h040);
        launch(32'h040, 1'b0);
        drain("R4 chain fully walked");

        // R6 end of chain without packet enable: no packet event
        put_desc(32'h200, 32'hB019_0005, 32'h1234, 32'h0);
        build_expect(32'h200);
        launch(32'h200, 1'b0);
        drain("R6 single descriptor without packet event");

        // R9 zero link without end of chain
        put_desc(32'h280, 32'h8002_0008, 32'h5000, 32'h0);
        build_expect(32'h280);
        launch(32'h280, 1'b0);
        drain("R9 broken chain reported");

        // R8 not owned, poll off
        put_desc(32'h300, 32'h0008_0004, 32'h6000, 32'h0);
        build_expect(32'h300);
        launch(32'h300, 1'b0);
        drain("R8 unowned descriptor ends walk");
        check(cur_desc_addr == 32'h300, "R11 address kept after stop", 96'(cur_desc_addr), 96'h300);

        // R7 not owned, poll on: two refused reads, then owned
        put_desc(32'h340, 32'h000B_0020, 32'h7000, 32'h0);
        flip_addr  = 32'h340;
        flip_after = 2;
        rd_q.push_back(32'h340);
        rd_q.push_back(32'h340);
        mem[32'h340 >> 2][31] = 1'b1;
        build_expect(32'h340);
        mem[32'h340 >> 2][31] = 1'b0;
        launch(32'h340, 1'b1);
        drain("R7 polling resumes when owned");
        ctl_bits = 3'b000;

        // R10 disable while a command is presented
        put_desc(32'h380, 32'h8008_0004, 32'h7100, 32'h0);
        build_expect(32'h380);
        eng_hold = 1'b1;
        launch(32'h380, 1'b0);
        for (int i = 0; i < 100 && !cmd_valid; i++) @(negedge clk);
        check(cmd_valid, "R10 command presented before disable", 96'(cmd_valid), 96'd1);
        ctl_bits = 3'b000;
        @(negedge clk);
        check(!cmd_valid && !mem_rd_req, "R10 disable drops command next cycle",
              96'({cmd_valid, mem_rd_req}), 96'd0);
        repeat (10) @(negedge clk);
        check(!cmd_valid && rd_q.size() == 0 && cmd_q.size() == 0, "R10 walker stays idle",
              96'(cmd_valid), 96'd0);
        eng_hold = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule